// File: doc/BRIEF.md
# Two-Wire Serial Control Register Slave

This block is a slave on a two-wire serial bus: the master drives the serial clock and one data wire that both ends share. The block holds three 8-bit control registers and drives their fields onto parallel outputs: an 8-bit video gain, a 5-bit black-level code, a high-gain select, a 2-bit test-mode field and a microphone AGC enable.

The bus carries two kinds of frame and has no select line. In a read/write frame the master sends an address, then a direction bit, then a data byte. In a reset frame the master sends a long run of ones and then two zeros, and every register returns to its default of zero. During the data phase of a read, the block drives the data wire through a separate output and output-enable, which the pad ring combines into one bidirectional pin.

The block runs on a fast system clock. It passes the serial clock and the data wire through synchronizers and acts on the rising and falling edges it detects, so the serial clock must be several times slower than the system clock.

Top module: `srb_slave`

## Requirements
- R1: The data wire is sampled on each rising serial-clock edge. A read/write frame is 13 bits: four address bits with the most significant first, then one direction bit, then eight data bits with the most significant first.
- R2: A write to address 0 loads all eight bits onto `vid_gain`.
- R3: A write to address 1 sets `blk_level` from bits 4..0, `hi_gain` from bit 5 and `test_mode` from bits 7..6.
- R4: A write to address 2 sets `mic_agc_en` from bit 0. Reading address 2 returns that bit in position 0 and zeros in bits 7..1.
- R5: A direction bit of 1 means read and 0 means write. In a read, `sdio_oe` is high for the eight data bits. Each bit is launched after a falling serial-clock edge, so it is valid at the next rising edge, and the bits appear most significant first. `sdio_oe` is low at every other rising edge.
- R6: Addresses 3 to 14 are unused. A write to one of them changes no output, and a read of one returns 0x00.
- R7: A frame that starts with ones and contains at least sixteen ones, followed by two zeros, clears every register to 0x00. Runs longer than sixteen ones are accepted.
- R8: A zero after fewer than sixteen ones, or a one after the first zero of a reset run, aborts the frame. The registers are left unchanged and the next bit starts a new frame.
- R9: Frames may follow one another with no idle serial-clock cycles between them.
- R10: `wr_strobe` is high for exactly one system-clock cycle for each completed write frame, including writes to unused addresses. The strobe appears in the cycle the register is updated.
- R11: `rst` is a synchronous, active-high reset. It clears all registers, drops `sdio_oe` and returns the decoder to the start of a frame. If it falls in the same cycle as a pending write commit, the reset wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Serial clock from the master (asynchronous) |
| sdio_in | input | 1 | Data wire as received from the pad |
| sdio_out | output | 1 | Data bit driven during a read |
| sdio_oe | output | 1 | Output enable for the data pad |
| vid_gain | output | 8 | Video amplifier gain code |
| blk_level | output | 5 | Black clamp level code, 0 to 31 |
| hi_gain | output | 1 | Extra high-gain select |
| test_mode | output | 2 | Test-mode field |
| mic_agc_en | output | 1 | Microphone AGC enable |
| wr_strobe | output | 1 | One-cycle pulse when a write commits |

## Verification
The collision that matters is between the local synchronous reset and the commit of a write whose last data bit has just been sampled. Both act on the same registers within the few system-clock cycles of synchronizer latency. The bench completes a write to the misc register with all ones, then raises `rst` one cycle after the final rising serial-clock edge. It expects every field to read zero, no extra `wr_strobe` pulse, and a following read to return zero.

// File: rtl/srb_pkg.sv
package srb_pkg;

  typedef enum logic [2:0] {
    ST_HDR,
    ST_DIR,
    ST_WDATA,
    ST_RDATA,
    ST_RONES,
    ST_RZERO
  } dec_state_t;

  localparam int REG_GAIN = 0;
  localparam int REG_MISC = 1;
  localparam int REG_MIC  = 2;

  localparam int BLK_W    = 5;
  localparam int HI_BIT   = 5;
  localparam int TEST_LSB = 6;
  localparam int TEST_W   = 2;

endpackage

// File: rtl/srb_edge_sync.sv
module srb_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_a,
  input  logic sdio_a,
  output logic sdi_o,
  output logic rise_o,
  output logic fall_o
);

  logic [STAGES-1:0] ck_pipe = '0;
  logic [STAGES-1:0] dt_pipe = '0;
  logic              ck_last = 1'b0;

  always_ff @(posedge clk) begin
    ck_pipe <= {ck_pipe[STAGES-2:0], sclk_a};
    dt_pipe <= {dt_pipe[STAGES-2:0], sdio_a};
    ck_last <= ck_pipe[STAGES-1];
  end

  assign sdi_o  = dt_pipe[STAGES-1];
  assign rise_o = ck_pipe[STAGES-1] & ~ck_last & ~rst;
  assign fall_o = ~ck_pipe[STAGES-1] & ck_last & ~rst;

endmodule

// File: rtl/srb_frame_dec.sv
module srb_frame_dec
  import srb_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 8,
  parameter int RST_ONES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              wr_en_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic              clr_o,
  output logic              sdo_o,
  output logic              oe_o
);

  localparam int MAXW = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam int CW   = $clog2(MAXW);
  localparam int OW   = $clog2(RST_ONES + 1);

  dec_state_t        state;
  logic [CW-1:0]     bit_cnt;
  logic [ADDR_W-1:0] addr_sh;
  logic [DATA_W-1:0] data_sh;
  logic [DATA_W-1:0] rd_sh;
  logic [OW-1:0]     ones;
  logic              oe_q, sdo_q, wr_en_q, clr_q;
  logic [DATA_W-1:0] wr_data_q;
  logic [ADDR_W-1:0] addr_next;

  assign addr_next = {addr_sh[ADDR_W-2:0], sdi_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_HDR;
      bit_cnt   <= '0;
      addr_sh   <= '0;
      data_sh   <= '0;
      rd_sh     <= '0;
      ones      <= '0;
      oe_q      <= 1'b0;
      sdo_q     <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
      clr_q     <= 1'b0;
    end else begin
      wr_en_q <= 1'b0;
      clr_q   <= 1'b0;
      if (rise_i) begin
        unique case (state)
          ST_HDR: begin
            addr_sh <= addr_next;
            if (bit_cnt == CW'(ADDR_W - 1)) begin
              bit_cnt <= '0;
              if (&addr_next) begin
                state <= ST_RONES;
                ones  <= OW'(ADDR_W);
              end else begin
                state <= ST_DIR;
              end
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_DIR: begin
            bit_cnt <= '0;
            if (sdi_i) begin
              state <= ST_RDATA;
              rd_sh <= rd_data_i;
            end else begin
              state <= ST_WDATA;
            end
          end
          ST_WDATA: begin
            data_sh <= {data_sh[DATA_W-2:0], sdi_i};
            if (bit_cnt == CW'(DATA_W - 1)) begin
              state     <= ST_HDR;
              bit_cnt   <= '0;
              wr_en_q   <= 1'b1;
              wr_data_q <= {data_sh[DATA_W-2:0], sdi_i};
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_RDATA: begin
            if (bit_cnt == CW'(DATA_W - 1)) begin
              state   <= ST_HDR;
              bit_cnt <= '0;
              oe_q    <= 1'b0;
            end else begin
              bit_cnt <= bit_cnt + 1'b1;
            end
          end
          ST_RONES: begin
            if (sdi_i) begin
              if (ones != OW'(RST_ONES)) ones <= ones + 1'b1;
            end else if (ones == OW'(RST_ONES)) begin
              state <= ST_RZERO;
            end else begin
              state <= ST_HDR;
            end
          end
          ST_RZERO: begin
            state <= ST_HDR;
            if (!sdi_i) clr_q <= 1'b1;
          end
          default: state <= ST_HDR;
        endcase
      end else if (fall_i && state == ST_RDATA) begin
        oe_q  <= 1'b1;
        sdo_q <= rd_sh[DATA_W-1];
        rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign addr_o    = addr_sh;
  assign wr_en_o   = wr_en_q;
  assign wr_data_o = wr_data_q;
  assign clr_o     = clr_q;
  assign sdo_o     = sdo_q;
  assign oe_o      = oe_q;

  a_r5_oe_only_in_read: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (state == ST_RDATA));

  a_r10_write_pulse_single: assert property (@(posedge clk) disable iff (rst)
    wr_en_q |=> !wr_en_q);

  a_r7_clear_follows_zero: assert property (@(posedge clk) disable iff (rst)
    clr_q |-> ($past(state) == ST_RZERO));

  a_r1_header_bound: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HDR) |-> (bit_cnt < CW'(ADDR_W)));

  a_r8_ones_saturate: assert property (@(posedge clk) disable iff (rst)
    ones <= OW'(RST_ONES));

endmodule

// File: rtl/srb_regfile.sv
module srb_regfile
  import srb_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [DATA_W-1:0] gain_o,
  output logic [DATA_W-1:0] misc_o,
  output logic              mic_o,
  output logic              strobe_o
);

  logic [DATA_W-1:0] gain_q, misc_q;
  logic              mic_q, strobe_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      gain_q   <= '0;
      misc_q   <= '0;
      mic_q    <= 1'b0;
      strobe_q <= 1'b0;
    end else begin
      strobe_q <= we_i;
      if (we_i) begin
        case (addr_i)
          ADDR_W'(REG_GAIN): gain_q <= wdata_i;
          ADDR_W'(REG_MISC): misc_q <= wdata_i;
          ADDR_W'(REG_MIC):  mic_q  <= wdata_i[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_W'(REG_GAIN): rdata_o = gain_q;
      ADDR_W'(REG_MISC): rdata_o = misc_q;
      ADDR_W'(REG_MIC):  rdata_o = {{(DATA_W-1){1'b0}}, mic_q};
      default:           rdata_o = '0;
    endcase
  end

  assign gain_o   = gain_q;
  assign misc_o   = misc_q;
  assign mic_o    = mic_q;
  assign strobe_o = strobe_q;

  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (gain_q == '0 && misc_q == '0 && !mic_q && !strobe_q));

  a_r6_unused_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (we_i && !clr_i && addr_i > ADDR_W'(REG_MIC))
      |=> ($stable(gain_q) && $stable(misc_q) && $stable(mic_q)));

  a_r10_strobe_follows_write: assert property (@(posedge clk) disable iff (rst)
    strobe_q |-> $past(we_i));

endmodule

// File: rtl/srb_slave.sv
module srb_slave
  import srb_pkg::*;
#(
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 8,
  parameter int RST_ONES    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         sclk,
  input  logic         sdio_in,
  output logic         sdio_out,
  output logic         sdio_oe,
  output logic [7:0]   vid_gain,
  output logic [4:0]   blk_level,
  output logic         hi_gain,
  output logic [1:0]   test_mode,
  output logic         mic_agc_en,
  output logic         wr_strobe
);

  logic              sdi, rise, fall;
  logic [ADDR_W-1:0] addr;
  logic              wr_en, clr;
  logic [DATA_W-1:0] wr_data, rd_data, gain_w, misc_w;
  logic              mic_w, strobe_w;

  srb_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sclk_a(sclk), .sdio_a(sdio_in),
    .sdi_o(sdi), .rise_o(rise), .fall_o(fall)
  );

  srb_frame_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_ONES(RST_ONES)) u_dec (
    .clk(clk), .rst(rst), .rise_i(rise), .fall_i(fall), .sdi_i(sdi),
    .rd_data_i(rd_data), .addr_o(addr), .wr_en_o(wr_en), .wr_data_o(wr_data),
    .clr_o(clr), .sdo_o(sdio_out), .oe_o(sdio_oe)
  );

  srb_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .clr_i(clr), .we_i(wr_en), .addr_i(addr),
    .wdata_i(wr_data), .rdata_o(rd_data), .gain_o(gain_w), .misc_o(misc_w),
    .mic_o(mic_w), .strobe_o(strobe_w)
  );

  assign vid_gain   = gain_w[7:0];
  assign blk_level  = misc_w[BLK_W-1:0];
  assign hi_gain    = misc_w[HI_BIT];
  assign test_mode  = misc_w[TEST_LSB +: TEST_W];
  assign mic_agc_en = mic_w;
  assign wr_strobe  = strobe_w;

  a_r11_no_drive_in_reset: assert property (@(posedge clk)
    rst |=> !sdio_oe);

endmodule

// File: tb/srb_slave_tb_top.sv
module srb_slave_tb_top;

  localparam int HP = 8;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, sdio_in = 1'b0;
  logic sdio_out, sdio_oe, hi_gain, mic_agc_en, wr_strobe;
  logic [7:0] vid_gain;
  logic [4:0] blk_level;
  logic [1:0] test_mode;

  srb_slave dut_i (
    .clk(clk), .rst(rst), .sclk(sclk), .sdio_in(sdio_in),
    .sdio_out(sdio_out), .sdio_oe(sdio_oe), .vid_gain(vid_gain),
    .blk_level(blk_level), .hi_gain(hi_gain), .test_mode(test_mode),
    .mic_agc_en(mic_agc_en), .wr_strobe(wr_strobe)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, quiet = 0, strobes = 0, exp_wr = 0, nxt_wr = 0;
  logic [7:0] exp_gain = 0, exp_misc = 0, nxt_gain = 0, nxt_misc = 0;
  logic exp_mic = 0, nxt_mic = 0, exp_oe = 0, exp_bit = 0, sclk_q = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic logic [7:0] model_read(input logic [3:0] a);
    case (a)
      4'd0: return exp_gain;
      4'd1: return exp_misc;
      4'd2: return {7'd0, exp_mic};
      default: return 8'h00;
    endcase
  endfunction

  // every-clock comparison once the design has had time to settle
  always @(negedge clk) begin
    if (wr_strobe) strobes++;
    if (rst || (sclk && !sclk_q)) quiet = 0;
    else if (quiet < 1000) quiet++;
    sclk_q = sclk;
    if (!rst && quiet >= 7) begin
      chk(vid_gain == exp_gain, "R2 vid_gain", vid_gain, exp_gain);
      chk(blk_level == exp_misc[4:0], "R3 blk_level", blk_level, exp_misc[4:0]);
      chk(hi_gain == exp_misc[5], "R3 hi_gain", hi_gain, exp_misc[5]);
      chk(test_mode == exp_misc[7:6], "R3 test_mode", test_mode, exp_misc[7:6]);
      chk(mic_agc_en == exp_mic, "R4 mic_agc_en", mic_agc_en, exp_mic);
      chk(strobes == exp_wr, "R10 strobe count", strobes, exp_wr);
    end
  end

  task automatic send_bit(input bit b, input bit commit, input bit mid_rst);
    @(posedge clk); #1 sdio_in = b;
    repeat (HP - 1) @(posedge clk);
    @(negedge clk);
    chk(sdio_oe == exp_oe, "R5 sdio_oe at rising edge", sdio_oe, exp_oe);
    if (exp_oe) chk(sdio_out == exp_bit, "R5 read bit", sdio_out, exp_bit);
    @(posedge clk); #1 sclk = 1'b1;
    if (commit) begin
      exp_gain = nxt_gain; exp_misc = nxt_misc; exp_mic = nxt_mic; exp_wr = nxt_wr;
    end
    if (mid_rst) begin
      @(negedge clk); rst = 1'b1;
      repeat (6) @(posedge clk);
      #1 rst = 1'b0;
    end
    repeat (HP) @(posedge clk);
    #1 sclk = 1'b0;
  endtask

  task automatic rw_frame(input logic [3:0] a, input bit rd, input logic [7:0] d,
                          input bit mid_rst);
    logic [7:0] rexp;
    exp_oe = 0;
    for (int i = 3; i >= 0; i--) send_bit(a[i], 1'b0, 1'b0);
    send_bit(rd, 1'b0, 1'b0);
    rexp = model_read(a);
    nxt_gain = exp_gain; nxt_misc = exp_misc; nxt_mic = exp_mic; nxt_wr = exp_wr;
    if (mid_rst) begin
      nxt_gain = 0; nxt_misc = 0; nxt_mic = 0;
    end else if (!rd) begin
      nxt_wr = exp_wr + 1;
      if (a == 4'd0) nxt_gain = d;
      else if (a == 4'd1) nxt_misc = d;
      else if (a == 4'd2) nxt_mic = d[0];
    end
    for (int i = 7; i >= 0; i--) begin
      exp_oe = rd;
      exp_bit = rexp[i];
      send_bit(rd ? 1'b0 : d[i], i == 0, (i == 0) && mid_rst);
    end
    exp_oe = 0;
  endtask

  task automatic reset_frame(input int n_ones);
    exp_oe = 0;
    for (int i = 0; i < n_ones; i++) send_bit(1'b1, 1'b0, 1'b0);
    send_bit(1'b0, 1'b0, 1'b0);
    nxt_gain = 0; nxt_misc = 0; nxt_mic = 0; nxt_wr = exp_wr;
    send_bit(1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    // R11: state while reset is held
    chk(sdio_oe == 1'b0, "R11 oe in reset", sdio_oe, 0);
    chk(vid_gain == 8'h00, "R11 gain in reset", vid_gain, 0);
    chk({blk_level, hi_gain, test_mode, mic_agc_en} == 9'd0, "R11 fields in reset",
        {blk_level, hi_gain, test_mode, mic_agc_en}, 0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (10) @(posedge clk);

    // R1 R2 R5 R9: write then read back to back
    rw_frame(4'd0, 1'b0, 8'hA5, 1'b0);
    rw_frame(4'd0, 1'b1, 8'h00, 1'b0);
    // R3: all ones, then a mixed pattern
    rw_frame(4'd1, 1'b0, 8'hFF, 1'b0);
    rw_frame(4'd1, 1'b1, 8'h00, 1'b0);
    rw_frame(4'd1, 1'b0, 8'h2A, 1'b0);
    rw_frame(4'd1, 1'b1, 8'h00, 1'b0);
    // R4: only bit 0 kept
    rw_frame(4'd2, 1'b0, 8'hFF, 1'b0);
    rw_frame(4'd2, 1'b1, 8'h00, 1'b0);
    // R6: unused addresses
    rw_frame(4'd5, 1'b0, 8'h77, 1'b0);
    rw_frame(4'd5, 1'b1, 8'h00, 1'b0);
    rw_frame(4'd14, 1'b0, 8'hC3, 1'b0);
    rw_frame(4'd14, 1'b1, 8'h00, 1'b0);
    rw_frame(4'd0, 1'b1, 8'h00, 1'b0);
    // R7: minimum reset frame, then a longer run
    reset_frame(16);
    rw_frame(4'd1, 1'b1, 8'h00, 1'b0);
    rw_frame(4'd0, 1'b0, 8'h5A, 1'b0);
    rw_frame(4'd2, 1'b0, 8'h01, 1'b0);
    reset_frame(21);
    rw_frame(4'd0, 1'b1, 8'h00, 1'b0);
    // R8: zero after ten ones aborts
    rw_frame(4'd1, 1'b0, 8'h9C, 1'b0);
    for (int i = 0; i < 10; i++) send_bit(1'b1, 1'b0, 1'b0);
    send_bit(1'b0, 1'b0, 1'b0);
    rw_frame(4'd0, 1'b0, 8'h3C, 1'b0);
    rw_frame(4'd1, 1'b1, 8'h00, 1'b0);
    // R8: one after the first zero aborts
    for (int i = 0; i < 16; i++) send_bit(1'b1, 1'b0, 1'b0);
    send_bit(1'b0, 1'b0, 1'b0);
    send_bit(1'b1, 1'b0, 1'b0);
    rw_frame(4'd0, 1'b1, 8'h00, 1'b0);
    rw_frame(4'd1, 1'b1, 8'h00, 1'b0);
    // R11: reset collides with the commit of a write
    rw_frame(4'd1, 1'b0, 8'hFF, 1'b1);
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(misc_zero(), "R11 reset beats commit", {blk_level, hi_gain, test_mode}, 0);
    rw_frame(4'd1, 1'b1, 8'h00, 1'b0);
    rw_frame(4'd2, 1'b0, 8'h01, 1'b0);
    rw_frame(4'd2, 1'b1, 8'h00, 1'b0);
    repeat (20) @(posedge clk);
    @(negedge clk);
    chk(strobes == exp_wr, "R10 final strobe count", strobes, exp_wr);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  function automatic bit misc_zero();
    return blk_level == 5'd0 && !hi_gain && test_mode == 2'd0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule